// File: doc/BRIEF.md
# Cascaded Up/Down Position Counter with Frozen Multi-Byte Readout

This block keeps a 24-bit position count that a host reads one byte at a time over an 8-bit bus. The live count has two parts. The lower part is a 16-bit up/down counter, which steps once for each single-cycle count request; a direction input picks up or down. When that counter wraps, the block emits a one-cycle carry pulse that carries the count direction. An 8-bit extension counter steps on each of those pulses.

For readout there are two snapshot registers, one for the lower 16 bits and one for the extension byte. Both load together on the falling clock edge. While no read is in progress they follow the live counters. A read begins when both active-low access strobes are low at a falling edge. At that edge the snapshots take their final values and then stay frozen. Counting goes on underneath, so no counts are lost.

A carry pulse that is still waiting to reach the extension counter is folded into the captured extension byte. This keeps the captured 24-bit value equal to the true position at the moment of capture, even when the read starts next to a wrap. The freeze ends at the first falling edge where the strobes are released, provided the last byte was read while the value was frozen.

Top module: `posCascadeCounter`

## Requirements
- R1: The lower 16-bit counter steps by +1 (when `cntUp`=1) or -1 (when `cntUp`=0) on each rising edge where `cntReq`=1, and holds otherwise. It wraps from FFFFh to 0000h going up and from 0000h to FFFFh going down.
- R2: When the lower counter wraps on a rising edge, `cascPulse` is 1 for exactly the following clock cycle, and `cascUp` gives the direction of that wrap. With no wrap, `cascPulse` stays 0.
- R3: The 8-bit extension counter steps +1 or -1 (following `cascUp`) on the rising edge after each carry pulse, wraps modulo 256, and holds otherwise.
- R4: At a falling edge where the block is not frozen, both snapshots load. If `selN`=0 and `oeN`=0 at that edge, the block becomes frozen and the snapshots keep those values.
- R5: The 24-bit value {extension, lower} captured at the start of a read equals the true position after the most recent rising edge. This holds when the read starts one cycle before, on, or after a wrap in either direction; for example, a read that starts while the count is 00FFFFh, in the same cycle as an up-count request, returns 00h, FFh, FFh.
- R6: Counting and carry pulses continue while the block is frozen. A carry pulse during a read is not lost: the next read returns the updated live position.
- R7: The freeze persists across gaps in access until byte index 2 has been read during the freeze. After that, the first falling edge with `selN` or `oeN` high releases it, and the snapshots track again from the following falling edge.
- R8: With `selN`=0 and `oeN`=0, `dataOut` returns the extension byte for `byteSel`=0, lower bits 15:8 for `byteSel`=1, lower bits 7:0 for `byteSel`=2, and 00h for `byteSel`=3. When either strobe is high, `dataOut` is 00h.
- R9: With `rstN` low at a clock edge, both counters, both snapshots, the carry pulse and the freeze are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Counters use the rising edge; snapshot and freeze use the falling edge |
| rstN | input | 1 | Synchronous reset, active low |
| cntReq | input | 1 | Single-cycle count request |
| cntUp | input | 1 | Count direction: 1 = up, 0 = down |
| selN | input | 1 | Chip select, active low |
| oeN | input | 1 | Output enable, active low |
| byteSel | input | 2 | Byte index: 0 = extension, 1 = high, 2 = low |
| dataOut | output | 8 | Selected snapshot byte, zero when not accessed |
| cascPulse | output | 1 | Carry pulse, one cycle after a wrap of the lower counter |
| cascUp | output | 1 | Direction of the wrap that raised the carry pulse |

## Verification
The critical collision is a wrap of the lower counter landing next to the falling edge that starts a read, while the carry is still on its way to the extension counter. The bench forks a single up or down count request at the FFFFh/0000h boundary alongside a full three-byte read. The read starts one cycle before, in the same cycle as, and one cycle after the wrap. Each returned byte is compared against a 24-bit position model sampled at the capture edge. A follow-up read then confirms that the live extension count absorbed the carry.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

  // strobes from the control half to the datapath half
  typedef struct packed {
    logic cntEn;      // step the lower counter this rising edge
    logic cntUp;      // step direction
    logic latchLoad;  // snapshots load on this falling edge
    logic busEn;      // host access active, drive the bus
  } pccStrobe_t;

endpackage

// File: rtl/pcc_control.sv
module pcc_control
  import pcc_pkg::*;
#(
  parameter int NB    = 3,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntReq,
  input  logic             cntUp,
  input  logic             selN,
  input  logic             oeN,
  input  logic [SEL_W-1:0] byteSel,
  output pccStrobe_t       strobes,
  output logic             frozen
);

  localparam logic [SEL_W-1:0] LAST_IDX = SEL_W'(NB - 1);

  logic access;
  logic lastByte;
  logic frozenQ;
  logic lastSeenQ;

  assign access   = !selN && !oeN;
  assign lastByte = (byteSel == LAST_IDX);

  // freeze state lives on the falling edge, half a cycle from the counters
  always_ff @(negedge clk) begin
    if (!rstN) begin
      frozenQ   <= 1'b0;
      lastSeenQ <= 1'b0;
    end else if (!frozenQ) begin
      lastSeenQ <= 1'b0;
      if (access) frozenQ <= 1'b1;
    end else begin
      if (access && lastByte) lastSeenQ <= 1'b1;
      if (!access && lastSeenQ) begin
        frozenQ   <= 1'b0;
        lastSeenQ <= 1'b0;
      end
    end
  end

  always_comb begin
    strobes.cntEn     = cntReq;
    strobes.cntUp     = cntUp;
    strobes.latchLoad = !frozenQ;
    strobes.busEn     = access;
  end

  assign frozen = frozenQ;

endmodule

// File: rtl/pcc_byte_mux.sv
module pcc_byte_mux #(
  parameter int BUS_W = 8,
  parameter int NB    = 3,
  parameter int SEL_W = 2
) (
  input  logic [NB*BUS_W-1:0] packed24,
  input  logic [SEL_W-1:0]    byteSel,
  input  logic                busEn,
  output logic [BUS_W-1:0]    dataOut
);

  logic [BUS_W-1:0] bytes [NB];

  // index 0 is the most significant byte
  for (genvar k = 0; k < NB; k++) begin : g_slice
    assign bytes[k] = packed24[(NB-1-k)*BUS_W +: BUS_W];
  end

  always_comb begin
    dataOut = '0;
    for (int k = 0; k < NB; k++) begin
      if (busEn && (byteSel == SEL_W'(k))) dataOut = bytes[k];
    end
  end

endmodule

// File: rtl/pcc_datapath.sv
module pcc_datapath
  import pcc_pkg::*;
#(
  parameter int LOW_W = 16,
  parameter int EXT_W = 8,
  parameter int BUS_W = 8,
  parameter int NB    = 3,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  pccStrobe_t       strobes,
  input  logic [SEL_W-1:0] byteSel,
  output logic [BUS_W-1:0] dataOut,
  output logic             cascPulse,
  output logic             cascUp,
  output logic [LOW_W-1:0] lowCnt,
  output logic [EXT_W-1:0] extCnt,
  output logic [LOW_W-1:0] lowLatch,
  output logic [EXT_W-1:0] extLatch
);

  localparam logic [LOW_W-1:0] LOW_MAX = '1;
  localparam logic [LOW_W-1:0] LOW_MIN = '0;

  logic             wrapNow;
  logic [EXT_W-1:0] extAdj;

  assign wrapNow = strobes.cntEn &&
                   (strobes.cntUp ? (lowCnt == LOW_MAX) : (lowCnt == LOW_MIN));

  // live counters and carry pulse
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowCnt    <= '0;
      extCnt    <= '0;
      cascPulse <= 1'b0;
      cascUp    <= 1'b0;
    end else begin
      if (strobes.cntEn) lowCnt <= strobes.cntUp ? lowCnt + 1'b1 : lowCnt - 1'b1;
      cascPulse <= wrapNow;
      cascUp    <= wrapNow && strobes.cntUp;
      if (cascPulse) extCnt <= cascUp ? extCnt + 1'b1 : extCnt - 1'b1;
    end
  end

  // extension value with any carry still in flight folded in
  assign extAdj = cascPulse ? (cascUp ? extCnt + 1'b1 : extCnt - 1'b1) : extCnt;

  // snapshots load together on the falling edge
  always_ff @(negedge clk) begin
    if (!rstN) begin
      lowLatch <= '0;
      extLatch <= '0;
    end else if (strobes.latchLoad) begin
      lowLatch <= lowCnt;
      extLatch <= extAdj;
    end
  end

  pcc_byte_mux #(
    .BUS_W (BUS_W),
    .NB    (NB),
    .SEL_W (SEL_W)
  ) u_mux (
    .packed24 ({extLatch, lowLatch}),
    .byteSel  (byteSel),
    .busEn    (strobes.busEn),
    .dataOut  (dataOut)
  );

endmodule

// File: rtl/posCascadeCounter.sv
module posCascadeCounter
  import pcc_pkg::*;
#(
  parameter int LOW_W = 16,
  parameter int EXT_W = 8,
  parameter int BUS_W = 8,
  localparam int NB    = (LOW_W + EXT_W) / BUS_W,
  localparam int SEL_W = $clog2(NB)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntReq,
  input  logic             cntUp,
  input  logic             selN,
  input  logic             oeN,
  input  logic [SEL_W-1:0] byteSel,
  output logic [BUS_W-1:0] dataOut,
  output logic             cascPulse,
  output logic             cascUp
);

  pccStrobe_t       strobes;
  logic             frozen;
  logic [LOW_W-1:0] lowCnt;
  logic [EXT_W-1:0] extCnt;
  logic [LOW_W-1:0] lowLatch;
  logic [EXT_W-1:0] extLatch;

  pcc_control #(
    .NB    (NB),
    .SEL_W (SEL_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cntReq  (cntReq),
    .cntUp   (cntUp),
    .selN    (selN),
    .oeN     (oeN),
    .byteSel (byteSel),
    .strobes (strobes),
    .frozen  (frozen)
  );

  pcc_datapath #(
    .LOW_W (LOW_W),
    .EXT_W (EXT_W),
    .BUS_W (BUS_W),
    .NB    (NB),
    .SEL_W (SEL_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .byteSel   (byteSel),
    .dataOut   (dataOut),
    .cascPulse (cascPulse),
    .cascUp    (cascUp),
    .lowCnt    (lowCnt),
    .extCnt    (extCnt),
    .lowLatch  (lowLatch),
    .extLatch  (extLatch)
  );

endmodule

// File: rtl/pcc_checker.sv
module pcc_checker #(
  parameter int LOW_W = 16,
  parameter int EXT_W = 8,
  parameter int BUS_W = 8,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             cntReq,
  input logic             cntUp,
  input logic             selN,
  input logic             oeN,
  input logic [SEL_W-1:0] byteSel,
  input logic [BUS_W-1:0] dataOut,
  input logic             cascPulse,
  input logic             cascUp,
  input logic             frozen,
  input logic [LOW_W-1:0] lowCnt,
  input logic [EXT_W-1:0] extCnt,
  input logic [LOW_W-1:0] lowLatch,
  input logic [EXT_W-1:0] extLatch
);

  AST_LOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(cntReq)) |-> $stable(lowCnt)); // R1

  AST_CASC_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && cascPulse) |-> ($past(cntReq) && ($past(cntUp) == cascUp))); // R2

  AST_CASC_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    cascPulse |=> !cascPulse); // R2

  AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(cascPulse)) |-> $stable(extCnt)); // R3

  AST_FREEZE_START: assert property (@(negedge clk) disable iff (!rstN)
    ($past(rstN) && $rose(frozen)) |-> $past(!selN && !oeN)); // R4

  AST_FREEZE_HOLD: assert property (@(negedge clk) disable iff (!rstN)
    ($past(rstN) && $past(frozen)) |-> ($stable(lowLatch) && $stable(extLatch))); // R4

  AST_RELEASE_IDLE: assert property (@(negedge clk) disable iff (!rstN)
    ($past(rstN) && $fell(frozen)) |-> $past(selN || oeN)); // R7

  AST_BUS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (selN || oeN || (byteSel == SEL_W'(3))) |-> (dataOut == '0)); // R8

endmodule

bind posCascadeCounter pcc_checker #(
  .LOW_W (LOW_W),
  .EXT_W (EXT_W),
  .BUS_W (BUS_W),
  .SEL_W (SEL_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cntReq    (cntReq),
  .cntUp     (cntUp),
  .selN      (selN),
  .oeN       (oeN),
  .byteSel   (byteSel),
  .dataOut   (dataOut),
  .cascPulse (cascPulse),
  .cascUp    (cascUp),
  .frozen    (frozen),
  .lowCnt    (lowCnt),
  .extCnt    (extCnt),
  .lowLatch  (lowLatch),
  .extLatch  (extLatch)
);

// File: tb/tb_posCascadeCounter.sv
`timescale 1ns/1ps
module tb_posCascadeCounter;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cntReq = 1'b0;
  logic       cntUp = 1'b1;
  logic       selN = 1'b1;
  logic       oeN = 1'b1;
  logic [1:0] byteSel = 2'd0;
  logic [7:0] dataOut;
  logic       cascPulse;
  logic       cascUp;

  always #2.5 clk = ~clk; // 200 MHz

  posCascadeCounter dut (
    .clk       (clk),
    .rstN      (rstN),
    .cntReq    (cntReq),
    .cntUp     (cntUp),
    .selN      (selN),
    .oeN       (oeN),
    .byteSel   (byteSel),
    .dataOut   (dataOut),
    .cascPulse (cascPulse),
    .cascUp    (cascUp)
  );

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // position model from the requirements
  logic [23:0] modelPos = '0;
  logic [23:0] snapPos = '0;
  bit          benchFrozen = 0;
  bit          lastDone = 0;

  always @(posedge clk) begin
    if (!rstN) modelPos = '0;
    else if (cntReq) modelPos = cntUp ? modelPos + 24'd1 : modelPos - 24'd1;
  end

  // scoreboard queues
  logic [7:0] expQ[$];
  string      tagQ[$];
  bit         sampleEn = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] byteOf(input logic [23:0] p, input int k);
    if (k > 2) return 8'h00;
    return 8'(p >> ((2 - k) * 8));
  endfunction

  // monitor: compares bus against queued expectations after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sampleEn) begin
        if (expQ.size() == 0) check(1'b0, "scoreboard empty", 32'(dataOut), 0);
        else begin
          logic [7:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(dataOut == e, t, 32'(dataOut), 32'(e));
        end
      end
    end
  end

  // driver: one byte access, called at posedge+1, returns at posedge+1
  task automatic readByte(input int k, input string tag);
    bit wasFrozen;
    selN = 1'b0; oeN = 1'b0; byteSel = 2'(k);
    @(negedge clk);
    wasFrozen = benchFrozen;
    if (!benchFrozen) begin
      snapPos = modelPos;
      benchFrozen = 1;
    end
    if (wasFrozen && k == 2) lastDone = 1;
    expQ.push_back(byteOf(snapPos, k));
    tagQ.push_back(tag);
    sampleEn = 1;
    @(posedge clk); #1;
    sampleEn = 0;
  endtask

  task automatic endAccess();
    selN = 1'b1; oeN = 1'b1;
    @(negedge clk);
    if (benchFrozen && lastDone) begin
      benchFrozen = 0;
      lastDone = 0;
    end
    @(posedge clk); #1;
  endtask

  task automatic readAll(input string tag);
    readByte(0, tag);
    readByte(1, tag);
    readByte(2, tag);
    endAccess();
  endtask

  task automatic countN(input bit up, input int n);
    cntUp = up; cntReq = 1'b1;
    repeat (n) @(posedge clk);
    #1 cntReq = 1'b0;
  endtask

  task automatic wrapRead(input bit up, input int off, input string tag);
    fork
      begin
        cntUp = up; cntReq = 1'b1;
        @(posedge clk); #1 cntReq = 1'b0;
      end
      begin
        repeat (off) begin @(posedge clk); #1; end
        readAll(tag);
      end
    join
    @(posedge clk); #1;
    readAll({tag, " live after carry R6"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk); #1;
    check(dataOut == 8'h00, "R8 idle bus zero", 32'(dataOut), 0);
    check(cascPulse == 1'b0, "R9 carry cleared", 32'(cascPulse), 0);
    @(posedge clk); #1;
    readAll("R9 reset value");

    countN(1, 5);
    readAll("R1 up count");
    countN(0, 6);
    readAll("R1 R3 down wrap to FFFFFF");

    // carry pulse shape, up then down
    cntUp = 1'b1; cntReq = 1'b1;
    @(negedge clk); #1;
    check(cascPulse == 1'b0, "R2 no pulse before wrap", 32'(cascPulse), 0);
    @(posedge clk); #1 cntReq = 1'b0;
    @(negedge clk); #1;
    check(cascPulse == 1'b1, "R2 pulse after up wrap", 32'(cascPulse), 1);
    check(cascUp == 1'b1, "R2 up direction", 32'(cascUp), 1);
    @(negedge clk); #1;
    check(cascPulse == 1'b0, "R2 pulse one cycle", 32'(cascPulse), 0);
    @(posedge clk); #1;
    cntUp = 1'b0; cntReq = 1'b1;
    @(posedge clk); #1 cntReq = 1'b0;
    @(negedge clk); #1;
    check(cascPulse == 1'b1 && cascUp == 1'b0, "R2 pulse after down wrap",
          {cascPulse, cascUp}, 32'h2);
    @(posedge clk); #1;
    countN(1, 1);
    readAll("R3 extension wrap to 000000");

    // bring position to 00FFFF
    countN(1, 65535);
    readAll("R1 at 00FFFF");

    for (int off = 0; off < 3; off++) begin
      wrapRead(1, off, $sformatf("R5 up wrap read offset %0d", off));
      wrapRead(0, off, $sformatf("R5 down wrap read offset %0d", off));
    end

    // freeze held across a gap, counts continue underneath
    readByte(0, "R7 gap first byte");
    endAccess();
    countN(1, 3);
    readByte(3, "R8 index 3 reads zero");
    readByte(1, "R7 gap still frozen");
    readByte(2, "R7 gap still frozen");
    endAccess();
    readAll("R6 R7 new value after release");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule